// File: doc/BRIEF.md
# Serial Converter Readout Host

This block is the host side of a three-wire serial link to a 16-bit successive-approximation converter. It drives an active-low chip select and a serial clock, and it reads the converter's data line. Lowering chip select both starts the remote conversion and opens the transfer. The converter does not drive the line for the first clock cycles. It then holds the line low for one cycle, sends sixteen result bits with the most significant bit first, and pulls the line low again.

A frame starts on a start request or on a periodic trigger. The host runs a configurable number of serial clock cycles, with a floor of 22. It ignores the leading cycles, checks the zero before the data and the zero after it, and collects the sixteen result bits into a signed word. The word is presented with a one-cycle valid strobe, and an error flag is raised in the same cycle when either zero check fails. The serial clock comes from a divider of the system clock. Chip select then stays high for a programmable rest time before the next frame can begin.

Top module: `adc_rd_host`

## Requirements
- R1: While reset is active and in the cycle after it ends, cs_n_o and sck_o are 1, and valid_o, frame_err_o and data_o are 0.
- R2: In the idle state, start_i or a periodic trigger drives cs_n_o low at the next clock edge, with sck_o still high. A request that arrives while a frame or its rest time is in progress is dropped.
- R3: Each serial clock half period lasts H system cycles, where H is half_div_i, and a value of 0 is treated as 1. After chip select falls, the first half period is high, then low and high halves alternate. sck_o is 1 whenever cs_n_o is 1, so chip select stays low for (2N+1)*H cycles.
- R4: A frame has N full serial cycles, where N is the larger of cycles_i and 22. That gives exactly N falling edges of sck_o. cs_n_o rises when the high half of cycle N ends.
- R5: sdi_i is sampled in the last system cycle of each low half, which is just before a rising edge. Cycles 6 to 21 give the result bits from bit 15 down to bit 0, and data_o presents them as a two's-complement signed value.
- R6: valid_o is a one-cycle pulse that follows the sample of cycle 22, and it occurs while cs_n_o is low. data_o keeps its value until the next pulse.
- R7: frame_err_o is 1 only together with valid_o. It is 1 when the sample of cycle 5 or the sample of cycle 22 was 1.
- R8: After cs_n_o rises, it stays high for at least G+1 cycles, where G is gap_i and a value of 0 is treated as 1. It stays high for exactly G+1 cycles when a request is waiting.
- R9: While auto_i is 1, a trigger fires every P system cycles, where P is period_i and a value of 0 is treated as 1. The first trigger comes P cycles after auto_i rises, and the count restarts whenever auto_i is 0. A start request and a trigger in the same cycle launch one frame only.
- R10: half_div_i, cycles_i and gap_i are captured when a frame starts. Changing them during that frame has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one frame |
| auto_i | input | 1 | Enable the periodic trigger |
| period_i | input | PER_W | Trigger period in system cycles |
| half_div_i | input | DIV_W | Serial clock half period in system cycles |
| cycles_i | input | CYC_W | Serial clock cycles per frame (raised to 22) |
| gap_i | input | GAP_W | Minimum chip select high time |
| sdi_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select / conversion start |
| sck_o | output | 1 | Serial clock, idles high |
| data_o | output | 16 | Signed conversion result |
| valid_o | output | 1 | One-cycle result strobe |
| frame_err_o | output | 1 | Leading or trailing zero missing |

## Verification
The two launch sources can fire in the same cycle. The bench provokes this by holding auto_i for a known period and pulsing start_i exactly on the edge where the trigger counter wraps. It then requires one chip select fall and one valid strobe before the next trigger is due. A held start request also lands on frames in progress and on the rest time. For these cases the cycle-by-cycle model checks that the request is dropped, and that the rest-time length is still met exactly.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    localparam int ADC_BITS  = 16;
    localparam int LEAD_CYC  = 5;
    localparam int FIRST_CYC = LEAD_CYC + 1;
    localparam int LAST_CYC  = FIRST_CYC + ADC_BITS - 1;
    localparam int TRAIL_CYC = LAST_CYC + 1;
    localparam int MIN_FRAME = TRAIL_CYC;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/adc_rd_trigger.sv
module adc_rd_trigger #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_i,
    input  logic [PER_W-1:0] period_i,
    output logic             trig_o
);
    logic [PER_W-1:0] pcnt;
    logic [PER_W-1:0] per_eff;

    assign per_eff = (period_i == '0) ? PER_W'(1) : period_i;
    assign trig_o  = auto_i && (pcnt == per_eff - PER_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !auto_i) begin
            pcnt <= '0;
        end else if (trig_o) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + PER_W'(1);
        end
    end
endmodule

// File: rtl/adc_rd_clkgen.sv
module adc_rd_clkgen #(
    parameter int DIV_W = 8,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             half_end_o,
    output logic [IDX_W-1:0] hidx_o
);
    logic [DIV_W-1:0] hcnt;
    logic             wrap;

    assign wrap       = (hcnt == half_i - DIV_W'(1));
    assign half_end_o = run_i && wrap;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            hcnt   <= '0;
            hidx_o <= '0;
        end else if (wrap) begin
            hcnt   <= '0;
            hidx_o <= hidx_o + IDX_W'(1);
        end else begin
            hcnt   <= hcnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CYC_W = 8,
    parameter int GAP_W = 8,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic [DIV_W-1:0] half_div_i,
    input  logic [CYC_W-1:0] cycles_i,
    input  logic [GAP_W-1:0] gap_i,
    input  logic             half_end_i,
    input  logic [IDX_W-1:0] hidx_i,
    output logic             run_o,
    output logic [DIV_W-1:0] half_o,
    output logic             cs_n_o,
    output logic             sck_o,
    output logic             smp_o,
    output logic [CYC_W-1:0] kidx_o
);
    localparam logic [CYC_W-1:0] MIN_N = CYC_W'(MIN_FRAME);

    seq_state_t       st;
    logic [DIV_W-1:0] h_q, h_eff;
    logic [CYC_W-1:0] n_q, n_eff;
    logic [GAP_W-1:0] g_q, g_eff, gcnt;
    logic             last_half;

    assign h_eff = (half_div_i == '0) ? DIV_W'(1) : half_div_i;
    assign n_eff = (cycles_i < MIN_N) ? MIN_N : cycles_i;
    assign g_eff = (gap_i == '0) ? GAP_W'(1) : gap_i;

    assign last_half = (hidx_i == {n_q, 1'b0});
    assign run_o     = (st == ST_RUN);
    assign half_o    = h_q;
    assign smp_o     = half_end_i && hidx_i[0];
    assign kidx_o    = hidx_i[IDX_W-1:1] + CYC_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cs_n_o <= 1'b1;
            sck_o  <= 1'b1;
            h_q    <= DIV_W'(1);
            n_q    <= MIN_N;
            g_q    <= GAP_W'(1);
            gcnt   <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (go_i) begin
                        st     <= ST_RUN;
                        cs_n_o <= 1'b0;
                        sck_o  <= 1'b1;
                        h_q    <= h_eff;
                        n_q    <= n_eff;
                        g_q    <= g_eff;
                    end
                end
                ST_RUN: begin
                    if (half_end_i) begin
                        if (last_half) begin
                            st     <= ST_GAP;
                            cs_n_o <= 1'b1;
                            sck_o  <= 1'b1;
                            gcnt   <= '0;
                        end else begin
                            sck_o  <= hidx_i[0];
                        end
                    end
                end
                ST_GAP: begin
                    if (gcnt == g_q - GAP_W'(1)) begin
                        st <= ST_IDLE;
                    end else begin
                        gcnt <= gcnt + GAP_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_rd_rx.sv
module adc_rd_rx
    import adc_rd_pkg::*;
#(
    parameter int K_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_i,
    input  logic [K_W-1:0]             kidx_i,
    input  logic                       sdi_i,
    output logic signed [ADC_BITS-1:0] data_o,
    output logic                       valid_o,
    output logic                       err_o
);
    logic [ADC_BITS-1:0] shreg;
    logic                lead_bad;
    logic                at_lead, in_data, at_trail;

    assign at_lead  = (kidx_i == K_W'(LEAD_CYC));
    assign in_data  = (kidx_i >= K_W'(FIRST_CYC)) && (kidx_i <= K_W'(LAST_CYC));
    assign at_trail = (kidx_i == K_W'(TRAIL_CYC));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            lead_bad <= 1'b0;
            data_o   <= '0;
            valid_o  <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            if (smp_i) begin
                if (at_lead) begin
                    lead_bad <= sdi_i;
                end
                if (in_data) begin
                    shreg <= {shreg[ADC_BITS-2:0], sdi_i};
                end
                if (at_trail) begin
                    valid_o <= 1'b1;
                    data_o  <= $signed(shreg);
                    err_o   <= lead_bad | sdi_i;
                end
            end
        end
    end
endmodule

// File: rtl/adc_rd_host.sv
module adc_rd_host
    import adc_rd_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CYC_W = 8,
    parameter int GAP_W = 8,
    parameter int PER_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_i,
    input  logic                       auto_i,
    input  logic [PER_W-1:0]           period_i,
    input  logic [DIV_W-1:0]           half_div_i,
    input  logic [CYC_W-1:0]           cycles_i,
    input  logic [GAP_W-1:0]           gap_i,
    input  logic                       sdi_i,
    output logic                       cs_n_o,
    output logic                       sck_o,
    output logic signed [ADC_BITS-1:0] data_o,
    output logic                       valid_o,
    output logic                       frame_err_o
);
    localparam int IDX_W = CYC_W + 1;

    logic             trig, go, run, half_end, smp;
    logic [IDX_W-1:0] hidx;
    logic [DIV_W-1:0] half_q;
    logic [CYC_W-1:0] kidx;

    assign go = start_i | trig;

    adc_rd_trigger #(.PER_W(PER_W)) u_trig (
        .clk(clk), .rst(rst), .auto_i(auto_i), .period_i(period_i), .trig_o(trig)
    );

    adc_rd_clkgen #(.DIV_W(DIV_W), .IDX_W(IDX_W)) u_clk (
        .clk(clk), .rst(rst), .run_i(run), .half_i(half_q),
        .half_end_o(half_end), .hidx_o(hidx)
    );

    adc_rd_seq #(.DIV_W(DIV_W), .CYC_W(CYC_W), .GAP_W(GAP_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst(rst), .go_i(go), .half_div_i(half_div_i),
        .cycles_i(cycles_i), .gap_i(gap_i), .half_end_i(half_end), .hidx_i(hidx),
        .run_o(run), .half_o(half_q), .cs_n_o(cs_n_o), .sck_o(sck_o),
        .smp_o(smp), .kidx_o(kidx)
    );

    adc_rd_rx #(.K_W(CYC_W)) u_rx (
        .clk(clk), .rst(rst), .smp_i(smp), .kidx_i(kidx), .sdi_i(sdi_i),
        .data_o(data_o), .valid_o(valid_o), .err_o(frame_err_o)
    );
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk
    import adc_rd_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sck,
    input logic valid,
    input logic err
);
    logic       sck_d;
    logic [7:0] falls;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b1;
            falls <= '0;
        end else begin
            sck_d <= sck;
            if (cs_n) begin
                falls <= '0;
            end else if (sck_d && !sck && falls != 8'hFF) begin
                falls <= falls + 8'd1;
            end
        end
    end

    // R2
    cs_fall_sck_high_chk: assert property (@(posedge clk) disable iff (rst) $fell(cs_n) |-> sck);
    // R3
    sck_idle_high_chk: assert property (@(posedge clk) disable iff (rst) cs_n |-> sck);
    // R4
    min_falls_chk: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |-> (falls >= 8'(MIN_FRAME)));
    // R6
    valid_in_frame_chk: assert property (@(posedge clk) disable iff (rst) valid |-> !cs_n);
    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst) valid |=> !valid);
    // R7
    err_with_valid_chk: assert property (@(posedge clk) disable iff (rst) err |-> valid);
    // R8
    cs_rest_chk: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |=> cs_n);
endmodule

bind adc_rd_host adc_rd_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n_o), .sck(sck_o), .valid(valid_o), .err(frame_err_o)
);

// File: tb/sim_adc_rd_host.sv
`timescale 1ns/1ps
module sim_adc_rd_host;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        auto_i = 1'b0;
    logic [15:0] period_i = 16'd100;
    logic [7:0]  half_div_i = 8'd1;
    logic [7:0]  cycles_i = 8'd24;
    logic [7:0]  gap_i = 8'd1;
    logic        sdi_i = 1'b1;
    logic        cs_n_o, sck_o, valid_o, frame_err_o;
    logic signed [15:0] data_o;

    always #4 clk = ~clk;

    adc_rd_host u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .auto_i(auto_i), .period_i(period_i),
        .half_div_i(half_div_i), .cycles_i(cycles_i), .gap_i(gap_i), .sdi_i(sdi_i),
        .cs_n_o(cs_n_o), .sck_o(sck_o), .data_o(data_o), .valid_o(valid_o),
        .frame_err_o(frame_err_o)
    );

    int vec = 0;
    int fails = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vec++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // converter model: acts on sck falls observed mid-cycle
    logic [15:0] next_word = 16'h0;
    bit bad_lead = 0, bad_trail = 0;
    logic [15:0] s_word;
    bit s_bl, s_bt, s_act = 0, s_prev = 1;
    int s_f = 0, last_falls = 0;

    always @(negedge clk) begin
        if (cs_n_o) begin
            if (s_act) begin last_falls = s_f; s_act = 0; end
            s_f = 0;
            sdi_i = 1'b1;
        end else begin
            if (!s_act) begin s_act = 1; s_word = next_word; s_bl = bad_lead; s_bt = bad_trail; end
            if (s_prev && !sck_o) begin
                s_f++;
                if (s_f < 5) sdi_i = 1'b1;
                else if (s_f == 5) sdi_i = s_bl;
                else if (s_f <= 21) sdi_i = s_word[21 - s_f];
                else sdi_i = s_bt;
            end
        end
        s_prev = sck_o;
    end

    // run-length monitor
    int hi_cnt = 0, lo_cnt = 0, hi_last = 0, lo_last = 0, cs_falls = 0, valid_cnt = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (valid_o) valid_cnt++;
            if (cs_n_o) begin
                if (lo_cnt > 0) begin lo_last = lo_cnt; lo_cnt = 0; end
                hi_cnt++;
            end else begin
                if (hi_cnt > 0) begin hi_last = hi_cnt; hi_cnt = 0; cs_falls++; end
                lo_cnt++;
            end
        end
    end

    // cycle-by-cycle reference model
    int m_mode = 0, m_c = 0, m_N = 22, m_H = 1, m_G = 1, m_g = 0, m_pc = 0;
    int m_P, m_k;
    bit m_trg, m_lead = 0;
    logic [15:0] m_acc = 16'h0;
    bit e_cs = 1, e_sck = 1, e_val = 0, e_err = 0;
    logic [15:0] e_data = 16'h0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_pc = 0; m_acc = 0; m_lead = 0;
            e_cs = 1; e_sck = 1; e_val = 0; e_err = 0; e_data = 0;
        end else begin
            m_P = (period_i == 0) ? 1 : int'(period_i);
            m_trg = auto_i && (m_pc == m_P - 1);
            if (!auto_i || m_trg) m_pc = 0; else m_pc++;
            e_val = 0; e_err = 0;
            case (m_mode)
                0: if (start_i || m_trg) begin
                    m_mode = 1; m_c = 0;
                    m_H = (half_div_i == 0) ? 1 : int'(half_div_i);
                    m_N = (cycles_i < 22) ? 22 : int'(cycles_i);
                    m_G = (gap_i == 0) ? 1 : int'(gap_i);
                    e_cs = 0; e_sck = 1;
                end
                1: begin
                    if ((m_c % m_H == m_H - 1) && ((m_c / m_H) % 2 == 1)) begin
                        m_k = (m_c / m_H + 1) / 2;
                        if (m_k == 5) m_lead = sdi_i;
                        else if (m_k >= 6 && m_k <= 21) m_acc = {m_acc[14:0], sdi_i};
                        else if (m_k == 22) begin e_val = 1; e_data = m_acc; e_err = m_lead | sdi_i; end
                    end
                    m_c++;
                    if (m_c == (2 * m_N + 1) * m_H) begin
                        m_mode = 2; m_g = 0; e_cs = 1; e_sck = 1;
                    end else begin
                        e_sck = ((m_c / m_H) % 2 == 1) ? 1'b0 : 1'b1;
                    end
                end
                default: begin
                    m_g++;
                    if (m_g == m_G) m_mode = 0;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            vec++;
            if (cs_n_o !== e_cs) begin fails++; $display("FAIL R2/R4 cs_n actual=%0h expected=%0h", cs_n_o, e_cs); end
            if (sck_o !== e_sck) begin fails++; $display("FAIL R3 sck actual=%0h expected=%0h", sck_o, e_sck); end
            if (valid_o !== e_val) begin fails++; $display("FAIL R6 valid actual=%0h expected=%0h", valid_o, e_val); end
            if (frame_err_o !== e_err) begin fails++; $display("FAIL R7 err actual=%0h expected=%0h", frame_err_o, e_err); end
            if (data_o !== e_data) begin fails++; $display("FAIL R5 data actual=%0h expected=%0h", data_o, e_data); end
        end
    end

    task automatic wait_valid();
        int t = 0;
        while (!valid_o && t < 20000) begin @(negedge clk); t++; end
    endtask

    task automatic wait_cs_high();
        int t = 0;
        while (!cs_n_o && t < 20000) begin @(negedge clk); t++; end
        @(negedge clk);
    endtask

    task automatic run_frame(input logic [15:0] w, input int h, input int n, input int g,
                             input bit bl, input bit bt);
        int ne, he;
        ne = (n < 22) ? 22 : n;
        he = (h == 0) ? 1 : h;
        @(negedge clk);
        next_word = w; bad_lead = bl; bad_trail = bt;
        half_div_i = 8'(h); cycles_i = 8'(n); gap_i = 8'(g);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        wait_valid();
        chk(valid_o && (data_o == $signed(w)), "R5 result word", int'(data_o), int'($signed(w)));
        chk(frame_err_o == (bl | bt), "R7 framing flag", int'(frame_err_o), int'(bl | bt));
        wait_cs_high();
        chk(last_falls == ne, "R4 falling edges per frame", last_falls, ne);
        chk(lo_last == (2 * ne + 1) * he, "R3 chip select low time", lo_last, (2 * ne + 1) * he);
        repeat (((g == 0) ? 1 : g) + 2) @(negedge clk);
    endtask

    initial begin
        int f0, v0;
        repeat (3) @(negedge clk);
        // R1
        chk(cs_n_o && sck_o && !valid_o && !frame_err_o && data_o == 0, "R1 reset state",
            {cs_n_o, sck_o, valid_o, frame_err_o}, 4'b1100);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n_o && sck_o && !valid_o && data_o == 0, "R1 after reset", {cs_n_o, sck_o, valid_o}, 3'b110);

        run_frame(16'h1234, 1, 24, 2, 0, 0);
        run_frame(16'h8000, 2, 22, 3, 0, 0);
        chk(data_o < 0, "R5 negative result", int'(data_o), -32768);
        run_frame(16'h7FFF, 3, 30, 1, 0, 0);
        run_frame(16'hFFFF, 0, 10, 0, 0, 0);   // R4 clamp, R3 zero divider
        chk(data_o == -1, "R5 minus one", int'(data_o), -1);
        run_frame(16'hA5C3, 2, 24, 4, 1, 0);   // R7 leading
        run_frame(16'h0001, 1, 23, 1, 0, 1);   // R7 trailing
        run_frame(16'h0000, 2, 22, 2, 0, 0);

        // R8 and R2: held request lands in frames and in the rest time
        @(negedge clk); half_div_i = 1; cycles_i = 22; gap_i = 6; next_word = 16'h5A5A;
        f0 = cs_falls;
        start_i = 1'b1;
        while (cs_falls < f0 + 2) @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk(hi_last == 7, "R8 rest time with pending request", hi_last, 7);
        wait_cs_high();
        repeat (10) @(negedge clk);

        // R10: configuration changed mid-frame
        @(negedge clk); half_div_i = 2; cycles_i = 24; gap_i = 2; next_word = 16'h3C3C;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (20) @(negedge clk);
        half_div_i = 5; cycles_i = 40; gap_i = 9;
        wait_valid();
        chk(data_o == 16'sh3C3C, "R10 result unaffected", int'(data_o), 16'h3C3C);
        wait_cs_high();
        chk(last_falls == 24, "R10 cycle count kept", last_falls, 24);
        chk(lo_last == 98, "R10 divider kept", lo_last, 98);
        repeat (12) @(negedge clk);

        // R9 periodic trigger
        half_div_i = 1; cycles_i = 22; gap_i = 1; next_word = 16'h0F0F; period_i = 300;
        f0 = cs_falls;
        auto_i = 1'b1;
        repeat (1000) @(negedge clk);
        auto_i = 1'b0;
        wait_cs_high();
        chk(cs_falls - f0 == 3, "R9 trigger count", cs_falls - f0, 3);
        repeat (5) @(negedge clk);

        // R9 start and trigger in the same cycle
        period_i = 400;
        f0 = cs_falls; v0 = valid_cnt;
        auto_i = 1'b1;
        repeat (399) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(!cs_n_o, "R2 launch on coincident request", int'(cs_n_o), 0);
        repeat (300) @(negedge clk);
        auto_i = 1'b0;
        repeat (5) @(negedge clk);
        chk(cs_falls - f0 == 1, "R9 single frame on coincidence", cs_falls - f0, 1);
        chk(valid_cnt - v0 == 1, "R9 single result on coincidence", valid_cnt - v0, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            vec++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
            $finish;
        end
    end
endmodule